// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block is the staging store that lets a host controller move a whole SMBus block transfer through one byte-wide data port. Before a block write, software loads the transfer length into a count register and pushes the payload through the port. The bus engine then fetches the bytes from a transmit stream. During a block read, the engine hands over the received count byte and the payload on a receive stream. Software later pops the payload through the same port. A single shared index serves both directions of the host port. Any read of the host control register sets that index back to zero as a side effect.

A two-bit mode register gates the buffer. One bit requests hardware packet error checking and is only passed on. The other bit switches buffered operation on. Even with that bit set, a transaction flagged as plain I2C bypasses the buffer, and another path serves it. A received count outside 1..DEPTH is reported on an error output. Bytes past the usable length are dropped.

Stream rules: the transmit stream follows valid/ready. Once `tx_valid` is high it stays high, with the same entry, until `tx_ready` accepts it or the session ends. The receive stream never applies back-pressure: `rx_ready` is high for the whole of a buffered read session and low otherwise.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the mode register reads 0x00, the count register reads 0x00, `len_err`, `buf_used` and `tx_valid` are 0, and the port index is 0 with every entry holding 0x00.
- R2: A mode write stores bit 1 as the buffer enable (`buf_en`) and bit 0 as the error-check enable (`pec_en`). Both read back on `mode_rdata[1:0]`, and bits 7..2 always read 0.
- R3: Each cycle with `port_wr` or `port_rd` high is one access to the entry at the port index. A write stores `port_wdata` there, a read returns it on `port_rdata` in the same cycle, and the index then advances by one.
- R4: A cycle with `ctl_rd` high sets the index to 0. If a port access falls in the same cycle, the access targets entry 0 and the index ends at 1.
- R5: Once entry DEPTH-1 has been accessed, further port writes are ignored and port reads return 0x00, until `ctl_rd` clears the index.
- R6: A transaction uses the buffer only if `buf_en` is 1 and `xact_i2c` is 0 at `xact_start`. Otherwise `buf_used`, `tx_valid` and `rx_ready` stay 0 for that transaction.
- R7: In a buffered write session (`xact_rd`=0) the transmit stream presents entries 0 to count-1 in order. `tx_last` is high on the final entry, and `tx_valid` holds until accepted.
- R8: In a buffered read session `rx_ready` is 1. A beat with `rx_is_count`=1 loads the count register and is not stored. Later beats are stored from entry 0 upward.
- R9: A received count of 0 or above DEPTH raises `len_err`. Data beats beyond min(count, DEPTH) are discarded, so a count of 0 stores nothing and a count above DEPTH stores the first DEPTH beats.
- R10: A buffered write session started with a count of 0 or above DEPTH raises `len_err` and presents no transmit beat.
- R11: `len_err` stays set until the next `xact_start`, which clears it unless R10 sets it again.
- R12: When a received count beat and a `cnt_wr` fall in the same cycle, the received count wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode write data |
| mode_rdata | output | 8 | Mode register read value |
| pec_en | output | 1 | Error-check enable (mode bit 0) |
| buf_en | output | 1 | Buffer enable (mode bit 1) |
| ctl_rd | input | 1 | Host control register read strobe; clears the port index |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 8 | Count write data |
| cnt_rdata | output | 8 | Count register value |
| port_wr | input | 1 | Block data port write |
| port_rd | input | 1 | Block data port read |
| port_wdata | input | 8 | Block data port write byte |
| port_rdata | output | 8 | Block data port read byte |
| xact_start | input | 1 | Transaction start pulse from the bus engine |
| xact_rd | input | 1 | Transaction direction at start (1 = read) |
| xact_i2c | input | 1 | Transaction is a plain I2C block (bypasses buffer) |
| xact_end | input | 1 | Transaction end pulse |
| buf_used | output | 1 | Current transaction runs through the buffer |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte is the final one |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Buffer accepts received byte |
| rx_data | input | 8 | Received byte |
| rx_is_count | input | 1 | Received byte is the length byte |
| len_err | output | 1 | Length out of range |

## Verification
The host control read and a port access can land in the same cycle. So can a received count beat and a software count write. Directed steps drive each pair in one cycle. The index case is judged by reading back entry 0 and the entry after it. The count case is judged on `cnt_rdata`. Random sessions with random transmit back-pressure then compare every transmitted and read-back byte against a model held in the bench.

// File: rtl/smbbuf_pkg.sv
package smbbuf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // bit 1: buffer enable, bit 0: error-check enable
  typedef struct packed {
    logic buf_en;
    logic pec_en;
  } mode_t;
endpackage

// File: rtl/blkbuf_modereg.sv
module blkbuf_modereg
  import smbbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_wr,
  input  byte_t mode_wdata,
  output mode_t mode_q,
  output byte_t mode_rdata
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^mode_wdata[7:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(mode_wdata[1:0]);
  end

  assign mode_rdata = {6'b0, mode_q};

  AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode_rdata[1:0] == $past(mode_wdata[1:0])); // R2
endmodule

// File: rtl/blkbuf_hostptr.sv
module blkbuf_hostptr #(
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_rd,
  input  logic          port_wr,
  input  logic          port_rd,
  output logic [PW-1:0] idx_eff,
  output logic          in_range
);
  localparam logic [PW-1:0] LIM = PW'(DEPTH);

  logic [PW-1:0] hptr;
  logic          access;

  assign access   = port_wr | port_rd;
  assign idx_eff  = ctl_rd ? '0 : hptr;
  assign in_range = idx_eff < LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hptr <= '0;
    else if (access && in_range) hptr <= idx_eff + PW'(1);
    else hptr <= idx_eff;
  end

  AST_HPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hptr <= LIM); // R5
  AST_HPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd && !access |=> hptr == '0); // R4
  AST_HPTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    hptr == LIM && !ctl_rd |=> hptr == LIM); // R5
  AST_HPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd && access && hptr < LIM |=> hptr == $past(hptr) + PW'(1)); // R3
endmodule

// File: rtl/blkbuf_store.sv
module blkbuf_store
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  byte_t         h_wdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  byte_t         e_wdata,
  output byte_t         h_rdata,
  output byte_t         e_rdata
);
  byte_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [AW-1:0] IDX = AW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (e_we && e_addr == IDX) mem[g] <= e_wdata;  // engine has priority
      else if (h_we && h_addr == IDX) mem[g] <= h_wdata;
    end
  end

  assign h_rdata = mem[h_addr];
  assign e_rdata = mem[e_addr];
endmodule

// File: rtl/blkbuf_engine.sv
module blkbuf_engine
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          xact_start,
  input  logic          xact_rd,
  input  logic          xact_i2c,
  input  logic          xact_end,
  input  logic          cnt_wr,
  input  byte_t         cnt_wdata,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  byte_t         rx_data,
  input  logic          rx_is_count,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          rx_ready,
  output logic          buf_used,
  output logic          len_err,
  output byte_t         cnt_q,
  output logic [PW-1:0] eptr,
  output logic          eng_we
);
  localparam logic [PW-1:0] LIM  = PW'(DEPTH);
  localparam byte_t         MAXC = BYTE_W'(DEPTH);

  logic          sess_act, sess_rd, err_q;
  logic [PW-1:0] lim;
  logic          rx_fire, tx_fire, use_buf;

  function automatic logic len_ok(input byte_t c);
    return (c != '0) && (c <= MAXC);
  endfunction

  function automatic logic [PW-1:0] lim_of(input byte_t c);
    if (c == '0) return '0;
    else if (c > MAXC) return LIM;
    else return PW'(c);
  endfunction

  assign use_buf  = buf_en && !xact_i2c;
  assign rx_ready = sess_act && sess_rd;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_valid = sess_act && !sess_rd && !err_q && (eptr < lim);
  assign tx_last  = tx_valid && (eptr == lim - PW'(1));
  assign tx_fire  = tx_valid && tx_ready;
  assign eng_we   = rx_fire && !rx_is_count && (eptr < lim);
  assign buf_used = sess_act;
  assign len_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_act <= 1'b0;
      sess_rd  <= 1'b0;
      eptr     <= '0;
      lim      <= '0;
      err_q    <= 1'b0;
    end else if (xact_start) begin
      sess_act <= use_buf;
      sess_rd  <= xact_rd;
      eptr     <= '0;
      if (use_buf && !xact_rd) begin
        lim   <= lim_of(cnt_q);
        err_q <= !len_ok(cnt_q);
      end else begin
        lim   <= '0;
        err_q <= 1'b0;
      end
    end else if (xact_end) begin
      sess_act <= 1'b0;
    end else begin
      if (rx_fire && rx_is_count) begin
        lim   <= lim_of(rx_data);
        err_q <= err_q | !len_ok(rx_data);
      end
      if (eng_we || tx_fire) eptr <= eptr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (rx_fire && rx_is_count) cnt_q <= rx_data;  // received count wins
    else if (cnt_wr) cnt_q <= cnt_wdata;
  end

  AST_EPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eptr <= LIM); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !xact_start && !xact_end |=> tx_valid && $stable(eptr)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !xact_start |=> err_q); // R11
  AST_NO_RX_STORE_BEFORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |=> eptr == '0); // R8
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [7:0] mode_wdata,
  output logic [7:0] mode_rdata,
  output logic       pec_en,
  output logic       buf_en,
  input  logic       ctl_rd,
  input  logic       cnt_wr,
  input  logic [7:0] cnt_wdata,
  output logic [7:0] cnt_rdata,
  input  logic       port_wr,
  input  logic       port_rd,
  input  logic [7:0] port_wdata,
  output logic [7:0] port_rdata,
  input  logic       xact_start,
  input  logic       xact_rd,
  input  logic       xact_i2c,
  input  logic       xact_end,
  output logic       buf_used,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_is_count,
  output logic       len_err
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  mode_t         mode_q;
  logic [PW-1:0] idx_eff, eptr;
  logic          in_range, eng_we;
  byte_t         h_rdata, e_rdata, cnt_q;

  blkbuf_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_q(mode_q), .mode_rdata(mode_rdata)
  );

  assign pec_en = mode_q.pec_en;
  assign buf_en = mode_q.buf_en;

  blkbuf_hostptr #(.DEPTH(DEPTH), .PW(PW)) u_hptr (
    .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd), .port_wr(port_wr),
    .port_rd(port_rd), .idx_eff(idx_eff), .in_range(in_range)
  );

  blkbuf_engine #(.DEPTH(DEPTH), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .buf_en(mode_q.buf_en),
    .xact_start(xact_start), .xact_rd(xact_rd), .xact_i2c(xact_i2c),
    .xact_end(xact_end), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_is_count(rx_is_count), .tx_valid(tx_valid), .tx_last(tx_last),
    .rx_ready(rx_ready), .buf_used(buf_used), .len_err(len_err),
    .cnt_q(cnt_q), .eptr(eptr), .eng_we(eng_we)
  );

  blkbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .h_we(port_wr && in_range), .h_addr(idx_eff[AW-1:0]), .h_wdata(port_wdata),
    .e_we(eng_we), .e_addr(eptr[AW-1:0]), .e_wdata(rx_data),
    .h_rdata(h_rdata), .e_rdata(e_rdata)
  );

  assign port_rdata = in_range ? h_rdata : '0;
  assign tx_data    = e_rdata;
  assign cnt_rdata  = cnt_q;

  AST_TX_ONLY_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> buf_used && !rx_ready); // R6
  AST_PORT_READ_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> port_rdata == 8'h00); // R5
endmodule

// File: tb/tb_smbus_blkbuf.sv
module tb_smbus_blkbuf;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 0, ctl_rd = 0, cnt_wr = 0, port_wr = 0, port_rd = 0;
  logic [7:0] mode_wdata = 0, cnt_wdata = 0, port_wdata = 0, rx_data = 0;
  logic       xact_start = 0, xact_rd = 0, xact_i2c = 0, xact_end = 0;
  logic       tx_ready = 0, rx_valid = 0, rx_is_count = 0;
  logic [7:0] mode_rdata, cnt_rdata, port_rdata, tx_data;
  logic       pec_en, buf_en, buf_used, tx_valid, tx_last, rx_ready, len_err;

  smbus_blkbuf #(.DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [7:0] mmem [DEPTH];
  int mptr = 0, meptr = 0, mlim = 0;

  function automatic int exp_limit(input logic [7:0] c);
    if (c == 0) return 0;
    if (c > DEPTH) return DEPTH;
    return int'(c);
  endfunction

  function automatic logic exp_bad(input logic [7:0] c);
    return (c == 0) || (c > DEPTH);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic mode_write(input logic [7:0] v);
    mode_wr = 1; mode_wdata = v; @(negedge clk); mode_wr = 0;
  endtask
  task automatic ctl();
    ctl_rd = 1; @(negedge clk); ctl_rd = 0; mptr = 0;
  endtask
  task automatic host_wr(input logic [7:0] b);
    port_wr = 1; port_wdata = b; @(negedge clk); port_wr = 0;
    if (mptr < DEPTH) begin mmem[mptr] = b; mptr++; end
  endtask
  task automatic host_rd(input string req);
    port_rd = 1; #1;
    chk(req, "port_rdata", port_rdata, (mptr < DEPTH) ? mmem[mptr] : 8'h00);
    @(negedge clk); port_rd = 0;
    if (mptr < DEPTH) mptr++;
  endtask
  task automatic set_cnt(input logic [7:0] c);
    cnt_wr = 1; cnt_wdata = c; @(negedge clk); cnt_wr = 0;
  endtask
  task automatic start(input logic rd, input logic i2c);
    xact_start = 1; xact_rd = rd; xact_i2c = i2c; @(negedge clk);
    xact_start = 0; meptr = 0; mlim = 0;
  endtask
  task automatic stop();
    xact_end = 1; @(negedge clk); xact_end = 0;
  endtask
  task automatic rx_send(input logic [7:0] d, input logic is_cnt);
    rx_valid = 1; rx_data = d; rx_is_count = is_cnt; #1;
    chk("R8", "rx_ready", rx_ready, 1);
    @(negedge clk); rx_valid = 0; rx_is_count = 0;
    if (is_cnt) mlim = exp_limit(d);
    else if (meptr < mlim) begin mmem[meptr] = d; meptr++; end
  endtask
  task automatic tx_drain(input int n, input bit rnd);
    int k = 0, guard = 0;
    while (k < n && guard < 400) begin
      tx_ready = rnd ? 1'($urandom % 2) : 1'b1; #1;
      chk("R7", "tx_valid", tx_valid, 1);
      chk("R7", "tx_data", tx_data, mmem[k]);
      chk("R7", "tx_last", tx_last, (k == n - 1));
      @(negedge clk);
      if (tx_ready) k++;
      guard++;
    end
    tx_ready = 0; #1;
    chk("R7", "tx_valid after final", tx_valid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1", "mode_rdata", mode_rdata, 0);
    chk("R1", "cnt_rdata", cnt_rdata, 0);
    chk("R1", "len_err", len_err, 0);
    chk("R1", "buf_used", buf_used, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    @(negedge clk);
    host_rd("R1");
    ctl();

    // R2 mode register
    mode_write(8'hFF); #1;
    chk("R2", "mode_rdata ff", mode_rdata, 8'h03);
    chk("R2", "pec_en", pec_en, 1);
    chk("R2", "buf_en", buf_en, 1);
    @(negedge clk);
    mode_write(8'h01); #1;
    chk("R2", "mode_rdata 01", mode_rdata, 8'h01);
    chk("R2", "buf_en off", buf_en, 0);
    @(negedge clk);
    mode_write(8'h02);

    // R3 successive port accesses
    ctl();
    for (int i = 0; i < 5; i++) host_wr(8'h10 + 8'(i));
    ctl();
    for (int i = 0; i < 5; i++) host_rd("R3");

    // R4 control read in same cycle as a write: entry 0, index ends at 1
    ctl_rd = 1; port_wr = 1; port_wdata = 8'hA5; @(negedge clk);
    ctl_rd = 0; port_wr = 0; mmem[0] = 8'hA5; mptr = 1;
    host_rd("R4");
    ctl(); host_rd("R4");
    // R4 control read in same cycle as a read
    host_rd("R4");
    ctl_rd = 1; port_rd = 1; #1;
    chk("R4", "same-cycle read", port_rdata, 8'hA5);
    @(negedge clk); ctl_rd = 0; port_rd = 0; mptr = 1;
    host_rd("R4");

    // R5 saturation
    ctl();
    for (int i = 0; i < DEPTH + 2; i++) host_wr(8'h40 + 8'(i));
    ctl();
    for (int i = 0; i < DEPTH + 2; i++) host_rd("R5");
    chk("R5", "last entry kept", mmem[DEPTH-1], 8'h40 + 8'(DEPTH - 1));

    // R6 bypass: buffer disabled, and I2C with buffer enabled
    mode_write(8'h00); set_cnt(8'd3);
    start(1'b0, 1'b0); #1;
    chk("R6", "buf_used disabled", buf_used, 0);
    chk("R6", "tx_valid disabled", tx_valid, 0);
    @(negedge clk); stop();
    mode_write(8'h02);
    start(1'b1, 1'b1); #1;
    chk("R6", "buf_used i2c", buf_used, 0);
    chk("R6", "rx_ready i2c", rx_ready, 0);
    @(negedge clk); stop();

    // R7 directed write session with back-pressure
    ctl();
    for (int i = 0; i < 4; i++) host_wr(8'hC0 + 8'(i));
    set_cnt(8'd4);
    start(1'b0, 1'b0); #1;
    chk("R6", "buf_used on", buf_used, 1);
    @(negedge clk);
    tx_drain(4, 1'b1);
    stop();

    // R8 read session
    start(1'b1, 1'b0);
    rx_send(8'd3, 1'b1); #1;
    chk("R8", "cnt_rdata", cnt_rdata, 3);
    chk("R8", "len_err", len_err, 0);
    @(negedge clk);
    rx_send(8'h71, 1'b0); rx_send(8'h72, 1'b0); rx_send(8'h73, 1'b0);
    stop(); ctl();
    for (int i = 0; i < 4; i++) host_rd("R8");

    // R9 count 0: error, nothing stored
    start(1'b1, 1'b0);
    rx_send(8'd0, 1'b1); #1;
    chk("R9", "len_err count 0", len_err, 1);
    @(negedge clk);
    rx_send(8'hEE, 1'b0);
    stop(); ctl(); host_rd("R9");
    // R11 cleared at next start
    start(1'b1, 1'b0); #1;
    chk("R11", "len_err cleared", len_err, 0);
    @(negedge clk);
    // R9 count above depth: first DEPTH stored
    rx_send(8'd40, 1'b1); #1;
    chk("R9", "len_err count 40", len_err, 1);
    @(negedge clk);
    for (int i = 0; i < DEPTH + 3; i++) rx_send(8'h80 + 8'(i), 1'b0);
    chk("R11", "len_err sticky", len_err, 1);
    stop(); ctl();
    for (int i = 0; i < DEPTH + 1; i++) host_rd("R9");

    // R10 bad write counts
    set_cnt(8'd0); start(1'b0, 1'b0); #1;
    chk("R10", "len_err cnt 0", len_err, 1);
    chk("R10", "tx_valid cnt 0", tx_valid, 0);
    @(negedge clk); stop();
    set_cnt(8'd33); start(1'b0, 1'b0); #1;
    chk("R10", "len_err cnt 33", len_err, 1);
    chk("R10", "tx_valid cnt 33", tx_valid, 0);
    @(negedge clk); stop();

    // R12 received count beats host count write
    start(1'b1, 1'b0);
    cnt_wr = 1; cnt_wdata = 8'h11;
    rx_send(8'd5, 1'b1); cnt_wr = 0; #1;
    chk("R12", "cnt_rdata", cnt_rdata, 5);
    @(negedge clk); stop();

    // random sessions
    for (int it = 0; it < 24; it++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      if (it % 2 == 0) begin
        ctl();
        for (int i = 0; i < n; i++) host_wr(8'($urandom));
        set_cnt(8'(n));
        start(1'b0, 1'b0);
        tx_drain(n, 1'b1);
        stop();
      end else begin
        start(1'b1, 1'b0);
        rx_send(8'(n), 1'b1);
        for (int i = 0; i < n; i++) rx_send(8'($urandom), 1'b0);
        #1; chk("R9", "len_err random", len_err, exp_bad(8'(n)));
        @(negedge clk);
        stop(); ctl();
        for (int i = 0; i < n; i++) host_rd("R8");
      end
    end

    summary();
    $finish;
  end
endmodule